// File: doc/BRIEF.md
# Relative-Time Systolic Event Queue

This block keeps a small set of timed events in time order, for a hardware scheduler that needs the earliest pending deadline or activation at every moment. Each event carries a time, a task identifier and a one-bit current/future marker. A cell does not store an absolute time. It stores the distance from the event held in the cell ahead of it. Only the head cell is measured from the present instant, so moving the whole queue forward in time changes one register.

New events enter at the head and move down a linear chain of identical cells, one cell per clock, until they reach their place. Removing the head moves every entry forward by one cell in a single cycle. A snapshot command copies every cell into its own backup register, and a restore command brings that snapshot back. A controller can therefore run a look-ahead over future events, which disturbs the queue, and then return the queue to the state it had before.

Top module: `relq_queue`

## Requirements
- R1: The head port shows the earliest event: `head_valid` is high exactly when the queue holds at least one event. `head_time`, `head_id` and `head_fut` belong to the entry with the smallest absolute time, all read directly from the first cell.
- R2: Opcode 1 (insert) adds the event (`cmd_time` measured from now, `cmd_id`, `cmd_fut`) in ascending absolute-time order. An event whose time equals that of a queued event is placed behind it, so equal times leave in arrival order.
- R3: Opcode 2 (extract) removes the head in one cycle. The following entry becomes the head, and its time becomes the sum of the removed head time and its own relative time, which keeps the absolute times unchanged.
- R4: Opcode 3 (advance) subtracts `cmd_time` from the head time and stops at zero. The absolute time of every other entry drops by the same amount that the head actually lost.
- R5: Opcode 4 (snapshot) copies every cell into its backup register. Opcode 5 (restore) reloads every cell from its backup. After a restore, the queue contents match the contents at the last snapshot, or an empty queue if no snapshot has been taken since reset.
- R6: When an insert finds all DEPTH cells occupied, the entry with the largest time (possibly the new one) is discarded. `overflow` pulses high for exactly one cycle, and the queue stays full.
- R7: While an inserted entry is still travelling down the chain, `ready` is low and no command is accepted. A command presented while `ready` is low has no effect. At most one entry travels the chain at any time, and the head does not change while `ready` is low.
- R8: Extract or advance on an empty queue has no effect. Opcodes 0, 6 and 7 do nothing.
- R9: After reset the queue is empty, `ready` is high and `overflow` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, accepted when `ready` is high |
| cmd_op | input | 3 | Opcode: 1 insert, 2 extract, 3 advance, 4 snapshot, 5 restore |
| cmd_time | input | TW | Event time for insert, amount for advance |
| cmd_id | input | IDW | Task identifier for insert |
| cmd_fut | input | 1 | Current/future marker for insert |
| ready | output | 1 | High when no inserted entry is travelling the chain |
| head_valid | output | 1 | Queue not empty |
| head_time | output | TW | Head time, measured from now |
| head_id | output | IDW | Head task identifier |
| head_fut | output | 1 | Head current/future marker |
| overflow | output | 1 | One-cycle pulse when a tail entry is discarded |

## Verification
Some properties are checked in every cycle:
- occupied cells form an unbroken run from the head;
- at most one entry is travelling the chain;
- the head stays still while `ready` is low;
- an overflow pulse occurs only when all cells are full;
- an extract on an empty queue leaves it empty;
- an advance never makes the head time larger;
- the new head time after an extract equals the two old relative times added.

Sorted order including tie-breaking, the exact contents after snapshot and restore, the choice of which entry is dropped on overflow, and the fact that commands during a ripple are ignored are shown only by the bench. It compares the design against a model of absolute times over directed cases and a random command mix, and drains the queue to check its contents.

// File: rtl/relq_pkg.sv
`timescale 1ns/1ps
package relq_pkg;

    // Opcodes seen on cmd_op; other codes do nothing
    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_INS     = 3'd1,
        OP_EXT     = 3'd2,
        OP_ADV     = 3'd3,
        OP_SNAP    = 3'd4,
        OP_RESTORE = 3'd5
    } relq_op_e;

    // Token passed from one cell to the next
    typedef enum logic [1:0] {
        TK_NONE  = 2'd0,
        TK_INS   = 2'd1,
        TK_SHIFT = 2'd2
    } relq_tok_e;

endpackage

// File: rtl/relq_cell.sv
`timescale 1ns/1ps
module relq_cell
    import relq_pkg::*;
#(
    parameter int TW   = 16,
    parameter int IDW  = 4,
    parameter bit HEAD = 1'b0,
    localparam int EW  = TW + IDW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  relq_op_e      op,
    input  logic [TW-1:0] amt,
    input  relq_tok_e     in_ctr,
    input  logic [EW-1:0] in_ent,
    input  logic [EW-1:0] nxt_ent,
    output relq_tok_e     out_ctr,
    output logic [EW-1:0] out_ent,
    output logic [EW-1:0] cur_ent
);

    typedef struct packed {
        logic           vld;
        logic [TW-1:0]  t;
        logic [IDW-1:0] id;
        logic           fut;
    } ent_t;

    typedef struct packed {
        ent_t      held;
        ent_t      bkp;
        relq_tok_e fctr;
        ent_t      fwd;
    } cell_t;

    cell_t cell_d, cell_q;
    ent_t  inc, nxt;

    assign inc = in_ent;
    assign nxt = nxt_ent;

    always_comb begin
        cell_d      = cell_q;
        cell_d.fctr = TK_NONE;
        cell_d.fwd  = '0;

        // broadcast commands (never coincide with a travelling token)
        case (op)
            OP_EXT: begin
                cell_d.held = nxt;
                if (HEAD && nxt.vld)
                    cell_d.held.t = cell_q.held.t + nxt.t;
            end
            OP_ADV: begin
                if (HEAD && cell_q.held.vld)
                    cell_d.held.t = (amt >= cell_q.held.t) ? '0
                                                           : cell_q.held.t - amt;
            end
            OP_SNAP:    cell_d.bkp  = cell_q.held;
            OP_RESTORE: cell_d.held = cell_q.bkp;
            default: ;
        endcase

        // systolic token handling
        case (in_ctr)
            TK_INS: begin
                if (!cell_q.held.vld) begin
                    cell_d.held = inc;
                end else if (inc.t < cell_q.held.t) begin
                    cell_d.held  = inc;
                    cell_d.fctr  = TK_SHIFT;
                    cell_d.fwd   = cell_q.held;
                    cell_d.fwd.t = cell_q.held.t - inc.t;
                end else begin
                    cell_d.fctr  = TK_INS;
                    cell_d.fwd   = inc;
                    cell_d.fwd.t = inc.t - cell_q.held.t;
                end
            end
            TK_SHIFT: begin
                cell_d.held = inc;
                if (cell_q.held.vld) begin
                    cell_d.fctr = TK_SHIFT;
                    cell_d.fwd  = cell_q.held;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cell_q <= '0;
        else        cell_q <= cell_d;
    end

    assign out_ctr = cell_q.fctr;
    assign out_ent = cell_q.fwd;
    assign cur_ent = cell_q.held;

    // R2: occupied cells stay contiguous from the head
    a_r2_no_hole: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_q.held.vld |-> !nxt.vld);

endmodule

// File: rtl/relq_queue.sv
`timescale 1ns/1ps
module relq_queue
    import relq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TW    = 16,
    parameter int IDW   = 4,
    localparam int EW   = TW + IDW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [2:0]     cmd_op,
    input  logic [TW-1:0]  cmd_time,
    input  logic [IDW-1:0] cmd_id,
    input  logic           cmd_fut,
    output logic           ready,
    output logic           head_valid,
    output logic [TW-1:0]  head_time,
    output logic [IDW-1:0] head_id,
    output logic           head_fut,
    output logic           overflow
);

    typedef struct packed {
        logic           vld;
        logic [TW-1:0]  t;
        logic [IDW-1:0] id;
        logic           fut;
    } ent_t;

    relq_tok_e     octr [DEPTH];
    logic [EW-1:0] oent [DEPTH];
    logic [EW-1:0] cur  [DEPTH];
    logic [DEPTH-1:0] busy_v, vld_v;

    logic      acc;
    relq_op_e  bop;
    relq_tok_e inj_ctr;
    ent_t      inj_ent, head_e, second_e;

    assign acc = cmd_valid && ready;

    always_comb begin
        bop     = OP_NONE;
        inj_ctr = TK_NONE;
        if (acc) begin
            case (cmd_op)
                3'd1:                   inj_ctr = TK_INS;
                3'd2, 3'd3, 3'd4, 3'd5: bop = relq_op_e'(cmd_op);
                default: ;
            endcase
        end
        inj_ent = '{vld: 1'b1, t: cmd_time, id: cmd_id, fut: cmd_fut};
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        relq_tok_e     c_in;
        logic [EW-1:0] e_in, e_nxt;
        if (i == 0) begin : g_first
            assign c_in = inj_ctr;
            assign e_in = inj_ent;
        end else begin : g_chain
            assign c_in = octr[i-1];
            assign e_in = oent[i-1];
        end
        if (i == DEPTH - 1) begin : g_last
            assign e_nxt = '0;
        end else begin : g_mid
            assign e_nxt = cur[i+1];
        end
        relq_cell #(.TW(TW), .IDW(IDW), .HEAD(i == 0)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .op     (bop),
            .amt    (cmd_time),
            .in_ctr (c_in),
            .in_ent (e_in),
            .nxt_ent(e_nxt),
            .out_ctr(octr[i]),
            .out_ent(oent[i]),
            .cur_ent(cur[i])
        );
        assign busy_v[i] = (octr[i] != TK_NONE);
        assign vld_v[i]  = cur[i][EW-1];
    end

    assign ready      = ~|busy_v;
    assign overflow   = busy_v[DEPTH-1];
    assign head_e     = cur[0];
    assign second_e   = (DEPTH > 1) ? cur[DEPTH > 1 ? 1 : 0] : '0;
    assign head_valid = head_e.vld;
    assign head_time  = head_e.t;
    assign head_id    = head_e.id;
    assign head_fut   = head_e.fut;

    // R7: a single token in flight, head frozen during a ripple
    a_r7_single_ripple: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy_v));
    a_r7_head_still: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(head_e));
    // R6: dropping a tail only happens on a full chain
    a_r6_ovf_full: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> &vld_v);
    // R8: extract on empty keeps it empty
    a_r8_ext_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 3'd2 && !head_valid) |=> !head_valid);
    // R4: advance never raises the head time
    a_r4_adv_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 3'd3 && head_valid) |=>
            (head_valid && head_time <= $past(head_time)));
    // R3: new head time is the sum of the two leading relative times
    a_r3_ext_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 3'd2 && second_e.vld) |=>
            (head_time == TW'($past(head_time) + $past(second_e.t))));

endmodule

// File: tb/sim_relq_queue.sv
`timescale 1ns/1ps
module sim_relq_queue;

    localparam int DEPTH = 8;
    localparam int TW    = 16;
    localparam int IDW   = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_valid = 1'b0;
    logic [2:0]     cmd_op = '0;
    logic [TW-1:0]  cmd_time = '0;
    logic [IDW-1:0] cmd_id = '0;
    logic           cmd_fut = 1'b0;
    logic           ready, head_valid, head_fut, overflow;
    logic [TW-1:0]  head_time;
    logic [IDW-1:0] head_id;

    always #4 clk = ~clk;

    relq_queue #(.DEPTH(DEPTH), .TW(TW), .IDW(IDW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_time(cmd_time), .cmd_id(cmd_id), .cmd_fut(cmd_fut),
        .ready(ready), .head_valid(head_valid), .head_time(head_time),
        .head_id(head_id), .head_fut(head_fut), .overflow(overflow)
    );

    int nchk = 0, nfail = 0, ovf_seen = 0, ovf_exp = 0;
    bit done = 1'b0;

    // model: absolute times measured from now
    int mt [DEPTH+1], mi [DEPTH+1], mf [DEPTH+1], cnt = 0;
    int bt [DEPTH+1], bi [DEPTH+1], bf [DEPTH+1], bcnt = 0;

    always @(negedge clk) if (rst_n && overflow) ovf_seen++;

    task automatic check(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_head(input string req);
        check(req, "head_valid", int'(head_valid), (cnt > 0) ? 1 : 0);
        if (cnt > 0) begin
            check(req, "head_time", int'(head_time), mt[0]);
            check(req, "head_id", int'(head_id), mi[0]);
            check(req, "head_fut", int'(head_fut), mf[0]);
        end
    endtask

    function automatic void m_insert(input int t, input int id, input int f);
        int pos = cnt;
        for (int i = 0; i < cnt; i++) if (mt[i] > t) begin pos = i; break; end
        for (int i = cnt; i > pos; i--) begin mt[i] = mt[i-1]; mi[i] = mi[i-1]; mf[i] = mf[i-1]; end
        mt[pos] = t; mi[pos] = id; mf[pos] = f;
        cnt++;
        if (cnt > DEPTH) begin cnt = DEPTH; ovf_exp++; end
    endfunction

    function automatic void m_extract();
        if (cnt == 0) return;
        for (int i = 0; i < cnt - 1; i++) begin mt[i] = mt[i+1]; mi[i] = mi[i+1]; mf[i] = mf[i+1]; end
        cnt--;
    endfunction

    function automatic void m_advance(input int a);
        int d;
        if (cnt == 0) return;
        d = (a < mt[0]) ? a : mt[0];
        for (int i = 0; i < cnt; i++) mt[i] -= d;
    endfunction

    function automatic void m_snap();
        for (int i = 0; i < DEPTH; i++) begin bt[i] = mt[i]; bi[i] = mi[i]; bf[i] = mf[i]; end
        bcnt = cnt;
    endfunction

    function automatic void m_restore();
        for (int i = 0; i < DEPTH; i++) begin mt[i] = bt[i]; mi[i] = bi[i]; mf[i] = bf[i]; end
        cnt = bcnt;
    endfunction

    task automatic issue(input int op, input int t, input int id, input int f);
        while (!ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op[2:0]; cmd_time = t[TW-1:0];
        cmd_id = id[IDW-1:0]; cmd_fut = f[0];
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!ready) @(negedge clk);
        case (op)
            1: m_insert(t, id, f);
            2: m_extract();
            3: m_advance(t);
            4: m_snap();
            5: m_restore();
            default: ;
        endcase
    endtask

    task automatic drain(input string req);
        while (cnt > 0) begin
            issue(2, 0, 0, 0);
            check_head(req);
        end
        check(req, "empty after drain", int'(head_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nfail, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9", "head_valid", int'(head_valid), 0);
        check("R9", "ready", int'(ready), 1);
        check("R9", "overflow", int'(overflow), 0);

        // R8: empty extract / advance / no-op opcodes
        issue(2, 0, 0, 0); check_head("R8");
        issue(3, 9, 0, 0); check_head("R8");
        issue(7, 5, 3, 1); check_head("R8");

        // R2 ordering and tie order
        issue(1, 50, 1, 0); check_head("R2");
        issue(1, 20, 2, 1); check_head("R2");
        issue(1, 50, 3, 0); check_head("R2");
        issue(1, 80, 4, 1); check_head("R2");
        issue(1, 20, 5, 0); check_head("R2");
        issue(6, 1, 1, 1);  check_head("R8");
        // R4 advance then saturate
        issue(3, 15, 0, 0); check_head("R4");
        issue(3, 100, 0, 0); check_head("R4");
        // R3 drain in order
        drain("R3");

        // R7: commands during a ripple are ignored
        issue(1, 10, 1, 0); issue(1, 20, 2, 0); issue(1, 30, 3, 0);
        cmd_valid = 1'b1; cmd_op = 3'd1; cmd_time = 16'd500; cmd_id = 4'd9; cmd_fut = 1'b1;
        @(negedge clk);
        check("R7", "ready during ripple", int'(ready), 0);
        cmd_op = 3'd2;
        @(negedge clk);
        check("R7", "ready still low", int'(ready), 0);
        cmd_valid = 1'b0;
        while (!ready) @(negedge clk);
        m_insert(500, 9, 1);
        check_head("R7");
        drain("R7");

        // R6 overflow: fill, then a large and a small extra
        for (int k = 0; k < DEPTH; k++) issue(1, 100 + 10 * k, k, k & 1);
        check("R6", "no overflow when filling", ovf_seen, 0);
        issue(1, 999, 15, 1);
        check("R6", "overflow pulses", ovf_seen, ovf_exp);
        issue(1, 5, 14, 0);
        check("R6", "overflow pulses", ovf_seen, ovf_exp);
        check_head("R6");
        drain("R6");

        // R5 snapshot / restore
        issue(1, 40, 1, 0); issue(1, 12, 2, 1); issue(1, 70, 3, 0);
        issue(4, 0, 0, 0);
        issue(2, 0, 0, 0); issue(3, 30, 0, 0); issue(1, 3, 7, 1);
        check_head("R5");
        issue(5, 0, 0, 0); check_head("R5");
        drain("R5");
        issue(5, 0, 0, 0); check_head("R5");
        drain("R5");

        // random mix checked against the model (R1)
        for (int n = 0; n < 600; n++) begin
            int r = $urandom_range(0, 99);
            if (r < 40)      issue(1, $urandom_range(0, 400), $urandom_range(0, 15), $urandom_range(0, 1));
            else if (r < 65) issue(2, 0, 0, 0);
            else if (r < 80) issue(3, $urandom_range(0, 60), 0, 0);
            else if (r < 90) issue(4, 0, 0, 0);
            else             issue(5, 0, 0, 0);
            check_head("R1");
        end
        check("R6", "overflow total", ovf_seen, ovf_exp);
        drain("R1");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nfail, nchk);
        $finish;
    end

endmodule